// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Integrator

This block produces the 10-bit control code for the digitally controlled oscillator of a frequency-locked loop. On each reference-period strobe it takes the requested multiplication factor and the measured factor, forms their signed difference, scales it by a power-of-two loop gain, and adds the result to a 20-bit fixed-point integrator. The integrator holds ten integer bits and ten fractional bits. The integer bits become the oscillator code. When dithering is on, a first-order phase accumulator driven by the fractional bits adds an occasional extra count to the code.

In direct mode the oscillator code is taken from a programmed value and the integrator does not change. On the first cycle of loop mode the integrator takes the direct code as its integer part, so the hand-over causes no frequency step. When the open-loop option is set and the lock indication is high, the integrator is frozen and the code is held. The integrator state can be read at all times on a dedicated output, so software can sample the settled code.

Top module: `fll_loop_integrator`

## Requirements
- R1: A synchronous reset sets the integrator state to 0x48400 (integer part 0x121, fraction 0). It clears the dither phase and carry and puts the block in direct mode. While in direct mode, dco_code equals dco_manual.
- R2: While loop mode is off (loop_en=0), dco_code follows dco_manual in the same cycle, and integ_state does not change whatever ref_tick and the factors do.
- R3: On the first clock edge at which loop_en is high after being low, integ_state is loaded with {dco_manual, 10'b0}. This load takes priority over any update.
- R4: In loop mode, at every clock edge with ref_tick=1, integ_state becomes integ_state + floor(((target_mult - meas_mult) * 1024) / 2^loop_gain). The difference is signed, and the division is an arithmetic right shift by loop_gain (0 to 15).
- R5: In loop mode, integ_state does not change at a clock edge where ref_tick=0.
- R6: The integrator update saturates. A result below zero gives 0x00000, and a result above 0xFFFFF gives 0xFFFFF.
- R7: In loop mode, with open_loop=1 and lock=1, ref_tick does not change integ_state, and dco_code stays at its held value when dithering is off.
- R8: In loop mode with dither_en=0 for at least the previous cycle, dco_code equals integ_state[19:10].
- R9: In loop mode with dither_en=1, each clock adds integ_state[9:0] into a 10-bit phase accumulator. The carry out of that addition is registered. dco_code = integ_state[19:10] + carry, clamped to 1023. When dithering is off or the block is in direct mode, the phase and carry are cleared.
- R10: integ_state presents the integer part on bits [19:10] and the fraction on bits [9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference period; enables an integrator update |
| loop_en | input | 1 | 1 selects loop mode, 0 selects direct mode |
| dco_manual | input | 10 | Direct oscillator code; also the integer preload on loop entry |
| target_mult | input | 16 | Requested multiplication factor |
| meas_mult | input | 16 | Measured multiplication factor |
| loop_gain | input | 4 | Gain setting g; the error is scaled by 2^-g |
| open_loop | input | 1 | Freeze the integrator while lock is high |
| lock | input | 1 | Lock indication from the lock detector |
| dither_en | input | 1 | Enable first-order dithering of the code LSB |
| dco_code | output | 10 | Oscillator control code |
| integ_state | output | 20 | Integrator readback: integer [19:10], fraction [9:0] |

## Verification
The bench drives the integrator into both saturation rails with full-scale errors at gain 0. A wrapping accumulator would show up as a code jumping from 1023 to near zero, or the reverse. With dithering enabled at the top rail, the bench confirms the code stays at 1023 instead of overflowing to 0 when the carry fires. Mode entry with a distinct direct code checks that the preload replaces the old state, rather than updating it or keeping a stale value. Random runs with all gains, sparse ticks, and lock and open-loop toggling compare every cycle against a bench model. These runs expose a logical instead of arithmetic shift of negative errors, updates without a tick, and updates during the frozen state.

// File: rtl/fll_loop_pkg.sv
package fll_loop_pkg;

    localparam int CODE_W  = 10;
    localparam int FRAC_W  = 10;
    localparam int MULT_W  = 16;
    localparam int GAIN_W  = 4;
    localparam int INTEG_W = CODE_W + FRAC_W;
    localparam int ACC_W   = MULT_W + 1 + FRAC_W + 1;

    localparam logic [CODE_W-1:0] MANUAL_RESET = 10'h121;

    typedef struct packed {
        logic [CODE_W-1:0] whole;
        logic [FRAC_W-1:0] frac;
    } integ_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } integ_act_e;

    // Clamp a signed accumulator result into the unsigned integrator range.
    function automatic integ_t clamp_state(input logic signed [ACC_W-1:0] v);
        integ_t r;
        if (v < 0) begin
            r = '0;
        end else if (v > $signed({{(ACC_W-INTEG_W){1'b0}}, {INTEG_W{1'b1}}})) begin
            r = '1;
        end else begin
            r = integ_t'(v[INTEG_W-1:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/fll_err_scale.sv
module fll_err_scale
    import fll_loop_pkg::*;
#(
    parameter int MW = MULT_W,
    parameter int FW = FRAC_W,
    parameter int GW = GAIN_W,
    parameter int AW = ACC_W
) (
    input  logic [MW-1:0]        target,
    input  logic [MW-1:0]        measured,
    input  logic [GW-1:0]        gain,
    output logic signed [AW-1:0] step
);
    localparam int EW = MW + 1;

    logic signed [EW-1:0] err;
    logic signed [AW-1:0] err_ext;
    logic signed [AW-1:0] err_fixed;

    always_comb begin
        err       = $signed({1'b0, target}) - $signed({1'b0, measured});
        err_ext   = AW'(err);
        err_fixed = err_ext <<< FW;
        step      = err_fixed >>> gain;
    end
endmodule

// File: rtl/fll_integrator.sv
module fll_integrator
    import fll_loop_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  integ_act_e            act,
    input  logic [CODE_W-1:0]     load_whole,
    input  logic signed [AW-1:0]  step,
    output integ_t                state
);
    logic signed [AW-1:0] sum;
    integ_t               nxt;

    always_comb begin
        sum = $signed({{(AW-INTEG_W){1'b0}}, state}) + step;
        unique case (act)
            ACT_LOAD: begin
                nxt.whole = load_whole;
                nxt.frac  = '0;
            end
            ACT_STEP: nxt = clamp_state(sum);
            default:  nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state.whole <= MANUAL_RESET;
            state.frac  <= '0;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/fll_dither.sv
module fll_dither
    import fll_loop_pkg::*;
#(
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [FW-1:0] frac,
    output logic          carry
);
    logic [FW-1:0] phase;
    logic [FW:0]   total;

    always_comb total = {1'b0, phase} + {1'b0, frac};

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= '0;
            carry <= 1'b0;
        end else begin
            phase <= total[FW-1:0];
            carry <= total[FW];
        end
    end
endmodule

// File: rtl/fll_code_sel.sv
module fll_code_sel
    import fll_loop_pkg::*;
#(
    parameter int CW         = CODE_W,
    parameter bit HAS_DITHER = 1'b1
) (
    input  logic          loop_active,
    input  logic [CW-1:0] whole,
    input  logic          carry,
    input  logic [CW-1:0] manual,
    output logic [CW-1:0] code
);
    logic [CW-1:0] loop_code;

    generate
        if (HAS_DITHER) begin : g_dither
            logic [CW:0] bumped;
            always_comb begin
                bumped    = {1'b0, whole} + {{CW{1'b0}}, carry};
                loop_code = bumped[CW] ? {CW{1'b1}} : bumped[CW-1:0];
            end
        end else begin : g_plain
            logic unused_carry;
            always_comb begin
                unused_carry = carry;
                loop_code    = whole;
            end
        end
    endgenerate

    always_comb code = loop_active ? loop_code : manual;
endmodule

// File: rtl/fll_loop_integrator.sv
module fll_loop_integrator
    import fll_loop_pkg::*;
#(
    parameter bit HAS_DITHER = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_tick,
    input  logic                loop_en,
    input  logic [CODE_W-1:0]   dco_manual,
    input  logic [MULT_W-1:0]   target_mult,
    input  logic [MULT_W-1:0]   meas_mult,
    input  logic [GAIN_W-1:0]   loop_gain,
    input  logic                open_loop,
    input  logic                lock,
    input  logic                dither_en,
    output logic [CODE_W-1:0]   dco_code,
    output logic [INTEG_W-1:0]  integ_state
);
    logic                    mode_q;
    logic signed [ACC_W-1:0] step;
    integ_act_e              act;
    integ_t                  state;
    logic                    carry;
    logic                    frozen;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= loop_en;
    end

    always_comb begin
        frozen = open_loop && lock;
        if (loop_en && !mode_q)
            act = ACT_LOAD;
        else if (loop_en && ref_tick && !frozen)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end

    fll_err_scale u_scale (
        .target   (target_mult),
        .measured (meas_mult),
        .gain     (loop_gain),
        .step     (step)
    );

    fll_integrator u_integ (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .load_whole (dco_manual),
        .step       (step),
        .state      (state)
    );

    fll_dither u_dither (
        .clk    (clk),
        .rst    (rst),
        .enable (dither_en && mode_q),
        .frac   (state.frac),
        .carry  (carry)
    );

    fll_code_sel #(.HAS_DITHER(HAS_DITHER)) u_sel (
        .loop_active (mode_q),
        .whole       (state.whole),
        .carry       (carry),
        .manual      (dco_manual),
        .code        (dco_code)
    );

    always_comb integ_state = state;
endmodule

// File: rtl/fll_loop_integrator_chk.sv
module fll_loop_integrator_chk
    import fll_loop_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ref_tick,
    input logic               loop_en,
    input logic               mode_q,
    input logic               open_loop,
    input logic               lock,
    input logic               dither_en,
    input logic [CODE_W-1:0]  dco_manual,
    input logic [CODE_W-1:0]  dco_code,
    input logic [INTEG_W-1:0] integ_state
);
    AST_DIRECT_CODE: assert property (@(posedge clk) disable iff (rst)
        !loop_en |=> (!loop_en || dco_code == dco_manual)); // R2

    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!loop_en && !mode_q) |=> $stable(integ_state)); // R2

    AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (loop_en && !mode_q) |=> integ_state == {$past(dco_manual), {FRAC_W{1'b0}}}); // R3

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loop_en && mode_q && !ref_tick) |=> $stable(integ_state)); // R5

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loop_en && mode_q && open_loop && lock) |=> $stable(integ_state)); // R7

    AST_DITHER_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !dither_en && $past(!dither_en)) |-> dco_code == integ_state[INTEG_W-1:FRAC_W]); // R8

    AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (dco_code == integ_state[INTEG_W-1:FRAC_W] ||
                    dco_code == integ_state[INTEG_W-1:FRAC_W] + 1'b1)); // R9
endmodule

bind fll_loop_integrator fll_loop_integrator_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_tick    (ref_tick),
    .loop_en     (loop_en),
    .mode_q      (mode_q),
    .open_loop   (open_loop),
    .lock        (lock),
    .dither_en   (dither_en),
    .dco_manual  (dco_manual),
    .dco_code    (dco_code),
    .integ_state (integ_state)
);

// File: tb/fll_loop_integrator_bench.sv
`timescale 1ns/1ps
module fll_loop_integrator_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        loop_en = 1'b0;
    logic [9:0]  dco_manual = 10'h121;
    logic [15:0] target_mult = 16'h05F5;
    logic [15:0] meas_mult = 16'h05F5;
    logic [3:0]  loop_gain = 4'd9;
    logic        open_loop = 1'b0;
    logic        lock = 1'b0;
    logic        dither_en = 1'b0;
    wire  [9:0]  dco_code;
    wire  [19:0] integ_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    longint m_int = 64'h48400;
    bit     m_mode = 1'b0;
    int     m_phase = 0;
    bit     m_carry = 1'b0;
    bit     m_entry = 1'b0;
    bit     m_tick_upd = 1'b0;

    always #10 clk = ~clk;

    fll_loop_integrator u_fll_loop_integrator (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .loop_en(loop_en),
        .dco_manual(dco_manual), .target_mult(target_mult), .meas_mult(meas_mult),
        .loop_gain(loop_gain), .open_loop(open_loop), .lock(lock),
        .dither_en(dither_en), .dco_code(dco_code), .integ_state(integ_state)
    );

    function automatic longint sat_add(longint cur, longint err, int g);
        longint s;
        s = cur + ((err * 1024) >>> g);
        if (s < 0) s = 0;
        if (s > 64'hFFFFF) s = 64'hFFFFF;
        return s;
    endfunction

    function automatic int exp_code();
        int c;
        if (!m_mode) return int'(dco_manual);
        c = int'(m_int >> 10) + int'(m_carry);
        if (c > 1023) c = 1023;
        return c;
    endfunction

    always @(posedge clk) begin
        int s;
        m_entry    = 1'b0;
        m_tick_upd = 1'b0;
        if (rst) begin
            m_int = 64'h48400; m_mode = 1'b0; m_phase = 0; m_carry = 1'b0;
        end else begin
            if (dither_en && m_mode) begin
                s = m_phase + int'(m_int & 64'h3FF);
                m_carry = (s >= 1024);
                m_phase = s % 1024;
            end else begin
                m_phase = 0; m_carry = 1'b0;
            end
            if (loop_en && !m_mode) begin
                m_int = longint'(dco_manual) << 10;
                m_entry = 1'b1;
            end else if (loop_en && ref_tick && !(open_loop && lock)) begin
                m_int = sat_add(m_int, longint'(target_mult) - longint'(meas_mult), int'(loop_gain));
                m_tick_upd = 1'b1;
            end
            m_mode = loop_en;
        end
    end

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step_chk();
        @(negedge clk);
        if (!m_mode)         chk("R2 integ", integ_state, m_int);
        else if (m_entry)    chk("R3 integ", integ_state, m_int);
        else if (m_tick_upd) chk("R4 R6 integ", integ_state, m_int);
        else if (open_loop && lock) chk("R7 integ", integ_state, m_int);
        else                 chk("R5 integ", integ_state, m_int);
        if (!m_mode)         chk("R2 code", dco_code, exp_code());
        else if (dither_en)  chk("R9 code", dco_code, exp_code());
        else                 chk("R8 code", dco_code, exp_code());
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 integ", integ_state, 64'h48400);
        chk("R1 code", dco_code, 10'h121);
        dco_manual = 10'h07B;
        #1 chk("R1 code follows direct", dco_code, 10'h07B);

        // R2: ticks in direct mode leave integrator alone
        ref_tick = 1'b1; target_mult = 16'hFFFF; meas_mult = 16'h0;
        repeat (3) step_chk();
        chk("R2 integ hold", integ_state, 64'h48400);

        // R3/R10: preload on entry
        ref_tick = 1'b0; dco_manual = 10'h2A5; loop_en = 1'b1;
        step_chk();
        chk("R10 readback", integ_state, 64'hA9400);
        chk("R10 whole", integ_state[19:10], 10'h2A5);
        chk("R10 frac", integ_state[9:0], 0);

        // R6: saturate high, then dither clamp (R9)
        loop_gain = 4'd0; ref_tick = 1'b1;
        repeat (2) step_chk();
        chk("R6 top rail", integ_state, 64'hFFFFF);
        ref_tick = 1'b0; dither_en = 1'b1;
        repeat (6) begin
            step_chk();
            chk("R9 clamp", dco_code, 10'h3FF);
        end
        dither_en = 1'b0;
        // R7: frozen while locked in open loop
        open_loop = 1'b1; lock = 1'b1; ref_tick = 1'b1;
        target_mult = 16'h0; meas_mult = 16'hFFFF;
        repeat (3) step_chk();
        chk("R7 frozen", integ_state, 64'hFFFFF);
        // R6: saturate low
        lock = 1'b0;
        repeat (2) step_chk();
        chk("R6 bottom rail", integ_state, 0);
        open_loop = 1'b0;

        // random phase
        for (int i = 0; i < 6000; i++) begin
            ref_tick = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 199) == 0) loop_en = ~loop_en;
            if ($urandom_range(0, 19) == 0) open_loop = $urandom_range(0, 1);
            if ($urandom_range(0, 19) == 0) lock = $urandom_range(0, 1);
            if ($urandom_range(0, 49) == 0) dither_en = $urandom_range(0, 1);
            if ($urandom_range(0, 29) == 0) dco_manual = 10'($urandom);
            if ($urandom_range(0, 39) == 0) loop_gain = 4'($urandom);
            target_mult = 16'($urandom_range(0, 65535));
            if ($urandom_range(0, 9) == 0)
                meas_mult = 16'($urandom);
            else
                meas_mult = 16'(int'(target_mult) + $signed($urandom_range(0, 64)) - 32);
            step_chk();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule